// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O peripheral. It serves one or more banks of pins, with a configurable number of pins per bank (up to 32). For each pin, software sets the direction and can invert the pin. Software changes output values only through separate write-one-to-set and write-one-to-clear registers. It reads the synchronized pin levels back through a data register.

Every pin can be armed to detect rising transitions, falling transitions, or both. A detected transition latches a pending bit, which software clears by writing a one to it. A companion status bit records whether the last captured transition was rising or falling. The pending bits of all banks are ORed into a single registered, active-high interrupt.

Each register has a fixed base offset. A bank's copy sits at that base plus four times the bank index. Reads return data one cycle after the request.

Top module: `pio_edge_ctrl`

## Requirements
- R1: The address is decoded as follows. `addr_i[7:4]` selects the register: 0 direction, 1 polarity, 2 data, 3 set, 4 clear, 5 rising enable, 6 falling enable, 9 pending, 0xA edge status. `addr_i[3:2]` selects the bank. A bank index at or above the bank count reads 0 and ignores writes. `rdata_o` updates on the clock edge that accepts a read.
- R2: A direction bit of 1 makes the pin an output (`pin_oe_o` high). A direction bit of 0 makes it an input.
- R3: A 1 in a write to the set register raises that pin's output value. A 1 in a write to the clear register lowers it. Zero bits leave the value unchanged.
- R4: Reading the data register returns every pin's level after the two-flop synchronizer, with input polarity applied.
- R5: A polarity bit of 1 has two effects. On an output pin, `pin_o` carries the inverted output value. On an input pin, the data readback and edge detection see the inverted level.
- R6: A rising-enable bit arms low-to-high detection for its pin and a falling-enable bit arms high-to-low detection. With neither bit set, no pending bit is raised for that pin.
- R7: Reading the pending register shows captured edges. Writing 1 to a bit clears it, and zero bits leave it unchanged. Without such a write, a pending bit stays set.
- R8: Bits at or above the pin count read 0 and ignore writes.
- R9: If an edge is captured in the same cycle as a write that clears the same pending bit, the bit stays set.
- R10: `irq_o` is the registered OR of all pending bits across all banks, and it is 0 after reset. All registers reset to 0.
- R11: When a pending bit is set, its edge-status bit becomes 1 for a rising edge and 0 for a falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| pin_i | input | NUM_BANKS*PIN_COUNT | Pin levels from the pads |
| pin_o | output | NUM_BANKS*PIN_COUNT | Output values to the pads |
| pin_oe_o | output | NUM_BANKS*PIN_COUNT | Output enables to the pads |
| irq_o | output | 1 | Combined interrupt, active high |

## Verification
The assertions check the following on every cycle, using bank 0:
- set and clear writes reach `pin_o`;
- direction writes reach `pin_oe_o`;
- pending bits never drop without a clear write;
- new pending bits appear only on armed pins;
- unimplemented read bits stay 0;
- the interrupt stays low while nothing is pending.

Only the directed scenarios can show the rest: the synchronizer latency seen through the data register, polarity on the input path, edge direction in the status register, the set-wins collision, and the handling of out-of-range banks.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned BUS_W = 32;

  localparam logic [3:0] RG_DIR  = 4'h0;
  localparam logic [3:0] RG_POL  = 4'h1;
  localparam logic [3:0] RG_DATA = 4'h2;
  localparam logic [3:0] RG_SET  = 4'h3;
  localparam logic [3:0] RG_CLR  = 4'h4;
  localparam logic [3:0] RG_RISE = 4'h5;
  localparam logic [3:0] RG_FALL = 4'h6;
  localparam logic [3:0] RG_PEND = 4'h9;
  localparam logic [3:0] RG_EDGE = 4'hA;

  typedef struct packed {
    logic dir;
    logic pol;
    logic set;
    logic clr;
    logic rise;
    logic fall;
    logic pend;
  } bank_wr_t;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pio_bank.sv
module pio_bank
  import pio_pkg::*;
#(
  parameter int unsigned PIN_COUNT = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  bank_wr_t             wr_i,
  input  logic [PIN_COUNT-1:0] wdata_i,
  input  logic [PIN_COUNT-1:0] pin_sync_i,
  output logic [PIN_COUNT-1:0] pin_o,
  output logic [PIN_COUNT-1:0] pin_oe_o,
  output logic [PIN_COUNT-1:0] dir_o,
  output logic [PIN_COUNT-1:0] pol_o,
  output logic [PIN_COUNT-1:0] lvl_o,
  output logic [PIN_COUNT-1:0] rise_o,
  output logic [PIN_COUNT-1:0] fall_o,
  output logic [PIN_COUNT-1:0] pend_o,
  output logic [PIN_COUNT-1:0] edge_o
);
  logic [PIN_COUNT-1:0] out_q, dir_q, pol_q, rise_q, fall_q, pend_q, edge_q, prev_q;
  logic [PIN_COUNT-1:0] lvl, hit_r, hit_f, hit, set_m, clr_m, ack_m;

  // input polarity only applies to pins configured as inputs
  assign lvl   = pin_sync_i ^ (pol_q & ~dir_q);
  assign hit_r = lvl & ~prev_q & rise_q;
  assign hit_f = ~lvl & prev_q & fall_q;
  assign hit   = hit_r | hit_f;

  assign set_m = wr_i.set  ? wdata_i : '0;
  assign clr_m = wr_i.clr  ? wdata_i : '0;
  assign ack_m = wr_i.pend ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      dir_q  <= '0;
      pol_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      pend_q <= '0;
      edge_q <= '0;
      prev_q <= '0;
    end else begin
      if (wr_i.dir)  dir_q  <= wdata_i;
      if (wr_i.pol)  pol_q  <= wdata_i;
      if (wr_i.rise) rise_q <= wdata_i;
      if (wr_i.fall) fall_q <= wdata_i;
      out_q  <= (out_q | set_m) & ~clr_m;
      // a fresh edge outranks a same-cycle acknowledge
      pend_q <= (pend_q & ~ack_m) | hit;
      edge_q <= (edge_q & ~hit) | hit_r;
      prev_q <= lvl;
    end
  end

  assign pin_o    = out_q ^ (pol_q & dir_q);
  assign pin_oe_o = dir_q;
  assign dir_o    = dir_q;
  assign pol_o    = pol_q;
  assign lvl_o    = lvl;
  assign rise_o   = rise_q;
  assign fall_o   = fall_q;
  assign pend_o   = pend_q;
  assign edge_o   = edge_q;
endmodule

// File: rtl/pio_edge_ctrl.sv
module pio_edge_ctrl
  import pio_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned PIN_COUNT = 24
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_i,
  input  logic                           we_i,
  input  logic [7:0]                     addr_i,
  input  logic [31:0]                    wdata_i,
  output logic [31:0]                    rdata_o,
  input  logic [NUM_BANKS*PIN_COUNT-1:0] pin_i,
  output logic [NUM_BANKS*PIN_COUNT-1:0] pin_o,
  output logic [NUM_BANKS*PIN_COUNT-1:0] pin_oe_o,
  output logic                           irq_o
);
  localparam int unsigned PINS_TOTAL = NUM_BANKS * PIN_COUNT;

  logic [3:0] reg_sel;
  logic [1:0] bank_idx;
  logic       wr_acc, rd_acc;

  assign reg_sel  = addr_i[7:4];
  assign bank_idx = addr_i[3:2];
  assign wr_acc   = req_i & we_i;
  assign rd_acc   = req_i & ~we_i;

  logic [PINS_TOTAL-1:0] pin_sync;

  pio_sync #(.WIDTH(PINS_TOTAL)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  logic [NUM_BANKS-1:0][PIN_COUNT-1:0] dir_w, pol_w, lvl_w, rise_w, fall_w, pend_w, edge_w;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_wr_t wr_b;
    logic     hit_b;

    assign hit_b     = wr_acc & (bank_idx == 2'(b));
    assign wr_b.dir  = hit_b & (reg_sel == RG_DIR);
    assign wr_b.pol  = hit_b & (reg_sel == RG_POL);
    assign wr_b.set  = hit_b & (reg_sel == RG_SET);
    assign wr_b.clr  = hit_b & (reg_sel == RG_CLR);
    assign wr_b.rise = hit_b & (reg_sel == RG_RISE);
    assign wr_b.fall = hit_b & (reg_sel == RG_FALL);
    assign wr_b.pend = hit_b & (reg_sel == RG_PEND);

    pio_bank #(.PIN_COUNT(PIN_COUNT)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr_b),
      .wdata_i   (wdata_i[PIN_COUNT-1:0]),
      .pin_sync_i(pin_sync[b*PIN_COUNT +: PIN_COUNT]),
      .pin_o     (pin_o[b*PIN_COUNT +: PIN_COUNT]),
      .pin_oe_o  (pin_oe_o[b*PIN_COUNT +: PIN_COUNT]),
      .dir_o     (dir_w[b]),
      .pol_o     (pol_w[b]),
      .lvl_o     (lvl_w[b]),
      .rise_o    (rise_w[b]),
      .fall_o    (fall_w[b]),
      .pend_o    (pend_w[b]),
      .edge_o    (edge_w[b])
    );
  end

  logic [PIN_COUNT-1:0] rd_val;

  always_comb begin
    rd_val = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_idx == 2'(b)) begin
        case (reg_sel)
          RG_DIR:  rd_val = dir_w[b];
          RG_POL:  rd_val = pol_w[b];
          RG_DATA: rd_val = lvl_w[b];
          RG_RISE: rd_val = rise_w[b];
          RG_FALL: rd_val = fall_w[b];
          RG_PEND: rd_val = pend_w[b];
          RG_EDGE: rd_val = edge_w[b];
          default: rd_val = '0;
        endcase
      end
    end
  end

  logic        pend_any;
  logic        irq_q;
  logic [31:0] rdata_q;

  assign pend_any = |pend_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (rd_acc) rdata_q <= 32'(rd_val);
      irq_q <= pend_any;
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/pio_edge_ctrl_chk.sv
module pio_edge_ctrl_chk #(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned PIN_COUNT = 24
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           req_i,
  input logic                           we_i,
  input logic [7:0]                     addr_i,
  input logic [31:0]                    wdata_i,
  input logic [31:0]                    rdata_o,
  input logic [NUM_BANKS*PIN_COUNT-1:0] pin_o,
  input logic [NUM_BANKS*PIN_COUNT-1:0] pin_oe_o,
  input logic                           irq_o,
  input logic [PIN_COUNT-1:0]           dir0,
  input logic [PIN_COUNT-1:0]           pol0,
  input logic [PIN_COUNT-1:0]           rise0,
  input logic [PIN_COUNT-1:0]           fall0,
  input logic [PIN_COUNT-1:0]           pend0,
  input logic                           pend_any
);
  logic wr0_dir, wr0_set, wr0_clr, wr0_pend;
  logic [PIN_COUNT-1:0] wd;

  assign wd       = wdata_i[PIN_COUNT-1:0];
  assign wr0_dir  = req_i & we_i & (addr_i[7:2] == 6'h00);
  assign wr0_set  = req_i & we_i & (addr_i[7:2] == 6'h0C);
  assign wr0_clr  = req_i & we_i & (addr_i[7:2] == 6'h10);
  assign wr0_pend = req_i & we_i & (addr_i[7:2] == 6'h24);

  AST_DIR_TO_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr0_dir |=> pin_oe_o[PIN_COUNT-1:0] == $past(wd)); // R2

  AST_SET_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr0_set |=> ((pin_o[PIN_COUNT-1:0] ^ (pol0 & dir0)) & $past(wd)) == $past(wd)); // R3

  AST_CLR_LOWERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr0_clr |=> ((pin_o[PIN_COUNT-1:0] ^ (pol0 & dir0)) & $past(wd)) == '0); // R3

  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr0_pend |=> ($past(pend0) & ~pend0) == '0); // R7

  AST_ARMED_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend0 & ~$past(pend0) & ~$past(rise0 | fall0)) == '0); // R6

  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_any && !$past(pend_any)) |-> !irq_o); // R10

  if (PIN_COUNT < 32) begin : g_unimpl
    AST_UNIMPL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rdata_o[31:PIN_COUNT] == '0); // R8
  end
endmodule

bind pio_edge_ctrl pio_edge_ctrl_chk #(
  .NUM_BANKS(NUM_BANKS),
  .PIN_COUNT(PIN_COUNT)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .pin_o   (pin_o),
  .pin_oe_o(pin_oe_o),
  .irq_o   (irq_o),
  .dir0    (dir_w[0]),
  .pol0    (pol_w[0]),
  .rise0   (rise_w[0]),
  .fall0   (fall_w[0]),
  .pend0   (pend_w[0]),
  .pend_any(pend_any)
);

// File: tb/tb_pio_edge_ctrl.sv
module tb_pio_edge_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 2;
  localparam int PC = 24;
  localparam int PT = NB * PC;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [PT-1:0] pins = '0;
  logic [PT-1:0] pout, poe;
  logic          irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_edge_ctrl #(.NUM_BANKS(NB), .PIN_COUNT(PC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pins), .pin_o(pout),
    .pin_oe_o(poe), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R10 irq after reset", 32'(irq), 0);
    check("R2 oe after reset", 32'(poe), 0);
    rd(8'h00, d); check("R10 dir reset", d, 0);
    rd(8'h90, d); check("R10 pend reset", d, 0);
  endtask

  task automatic t_direction;
    logic [31:0] d;
    wr(8'h00, 32'h0000_F0F0);
    check("R2 oe bank0", 32'(poe[PC-1:0]), 32'h0000_F0F0);
    wr(8'h04, 32'hFFFF_FFFF);
    check("R2 oe bank1", 32'(poe[PT-1:PC]), 32'h00FF_FFFF);
    rd(8'h04, d); check("R8 dir bank1 upper bits", d, 32'h00FF_FFFF);
    check("R1 bank0 untouched by bank1 write", 32'(poe[PC-1:0]), 32'h0000_F0F0);
  endtask

  task automatic t_set_clear;
    wr(8'h30, 32'h0000_00FF);
    check("R3 set", 32'(pout[7:0]), 32'hFF);
    wr(8'h40, 32'h0000_000F);
    check("R3 clear", 32'(pout[7:0]), 32'hF0);
    wr(8'h30, 32'h0);
    check("R3 zero set no change", 32'(pout[7:0]), 32'hF0);
    wr(8'h40, 32'h0);
    check("R3 zero clear no change", 32'(pout[7:0]), 32'hF0);
  endtask

  task automatic t_pol_out;
    wr(8'h10, 32'h0000_0030);
    check("R5 output inversion", 32'(pout[7:0]), 32'hC0);
    wr(8'h10, 32'h0);
  endtask

  task automatic t_data;
    logic [31:0] d;
    wr(8'h10, 32'h0001_0000);
    pins[PC-1:0] = 24'hA5_3C5A;
    pins[PT-1:PC] = 24'h12_3456;
    idle(3);
    rd(8'h20, d);
    check("R4 R5 data bank0", d, 32'h00A4_3C5A);
    rd(8'h24, d);
    check("R4 data bank1", d, 32'h0012_3456);
    wr(8'h10, 32'h0);
    pins = '0;
    idle(4);
  endtask

  task automatic t_rise;
    logic [31:0] d;
    wr(8'h50, 32'h0010_0000);
    pins[20] = 1'b1;
    idle(6);
    rd(8'h90, d); check("R6 rising captured", d, 32'h0010_0000);
    rd(8'hA0, d); check("R11 rising status", d, 32'h0010_0000);
    check("R10 irq set", 32'(irq), 1);
  endtask

  task automatic t_fall;
    logic [31:0] d;
    wr(8'h64, 32'h0000_0008);
    pins[PC+3] = 1'b1;
    idle(6);
    rd(8'h94, d); check("R6 rise ignored when only fall armed", d, 0);
    pins[PC+3] = 1'b0;
    idle(6);
    rd(8'h94, d); check("R6 falling captured", d, 32'h8);
    rd(8'hA4, d); check("R11 falling status", d, 0);
  endtask

  task automatic t_disarmed;
    logic [31:0] d;
    pins[9] = 1'b1; idle(5);
    pins[9] = 1'b0; idle(5);
    rd(8'h90, d); check("R6 disarmed pin", d, 32'h0010_0000);
  endtask

  task automatic t_ack;
    logic [31:0] d;
    wr(8'h90, 32'h0);
    rd(8'h90, d); check("R7 zero write ignored", d, 32'h0010_0000);
    wr(8'h90, 32'h0010_0000);
    rd(8'h90, d); check("R7 w1c", d, 0);
    idle(2);
    check("R10 irq held by bank1", 32'(irq), 1);
    wr(8'h94, 32'h8);
    idle(2);
    check("R10 irq cleared", 32'(irq), 0);
  endtask

  task automatic t_collision;
    logic [31:0] d;
    pins[20] = 1'b0; idle(6);
    @(negedge clk);
    pins[20] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 8'h90; wdata = 32'h0010_0000;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    rd(8'h90, d); check("R9 edge beats clear", d, 32'h0010_0000);
    wr(8'h90, 32'h0010_0000);
    rd(8'h90, d); check("R7 later clear works", d, 0);
  endtask

  task automatic t_edge_status;
    logic [31:0] d;
    wr(8'h50, 32'h0020_0000);
    wr(8'h60, 32'h0020_0000);
    pins[21] = 1'b1; idle(6);
    rd(8'hA0, d); check("R11 status rising", d & 32'h0020_0000, 32'h0020_0000);
    wr(8'h90, 32'h0020_0000);
    pins[21] = 1'b0; idle(6);
    rd(8'h90, d); check("R6 both armed fall", d, 32'h0020_0000);
    rd(8'hA0, d); check("R11 status falling", d & 32'h0020_0000, 0);
    wr(8'h90, 32'h0020_0000);
  endtask

  task automatic t_bank_range;
    logic [31:0] d;
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, d); check("R1 missing bank reads zero", d, 0);
    rd(8'h00, d); check("R1 missing bank write ignored b0", d, 32'h0000_F0F0);
    rd(8'h04, d); check("R1 missing bank write ignored b1", d, 32'h00FF_FFFF);
    rd(8'h30, d); check("R1 set register reads zero", d, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_direction();
    t_set_clear();
    t_pol_out();
    t_data();
    t_rise();
    t_fall();
    t_disarmed();
    t_ack();
    t_collision();
    t_edge_status();
    t_bank_range();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule